// File: doc/BRIEF.md
# USB Polling-Pair Packet Filter

This block sits after a USB byte decoder, before a capture buffer. It receives decoded packets as a byte stream and checks the packet identifier (PID) byte of each packet. When the IN or PING filter is enabled, it holds back a token of that type until it sees the next packet. If that next packet is a NAK handshake, the token and the NAK are discarded together. The pair carries no payload and would fill the capture buffer with polling traffic. Any other follow-up releases the held token intact ahead of the new packet. If no packet follows within a programmable number of bit times, the held token is also released. All other traffic passes through unchanged.

Both stream edges use valid/ready handshakes and carry per-byte `sop` and `eop` flags. A byte moves when `valid` and `ready` are both high at a rising clock edge. While `valid` is high and `ready` is low, the sender holds the byte and its flags steady. Back-pressure from `out_ready` reaches `in_ready` whenever a byte passes straight through. While a token is being collected, or a packet is being discarded, the input is accepted without regard to the output. While a held token is being released, the input is stalled. Two saturating counters report discarded pairs and PID errors.

Top module: `usb_nak_filter`

## Requirements
- R1: A packet whose first byte has an upper nibble that is not the bitwise complement of its lower nibble is discarded in full (no byte reaches the output), and `pid_err_count` increases by one.
- R2: A packet with a valid PID that is not held passes with identical bytes, `sop` and `eop`. A SOF token (lower nibble 0101, byte 0xA5) is never held, even when a NAK follows it.
- R3: With `cfg_in_nak_en`=1, an IN token (lower nibble 1001, byte 0x69) is held. If the next packet is a NAK (lower nibble 1010, byte 0x5A), both packets are discarded and `drop_count` increases by one.
- R4: With `cfg_ping_nak_en`=1, a PING token (lower nibble 0100, byte 0xB4) followed by a NAK is discarded in the same way. This enable is independent of the IN enable.
- R5: A held token followed by a valid non-NAK packet (DATA0 0xC3, DATA1 0x4B, ACK 0xD2, STALL 0x1E, NYET 0x96 or any other) appears on the output intact, immediately before that packet, which is also intact.
- R6: With an enable at 0, tokens of that type are not held, and their NAK pairs pass unchanged.
- R7: A held token is released intact once `cfg_timeout_bits` pulses of `bit_tick` occur without the start of a new packet.
- R8: `drop_count` and `pid_err_count` rise by at most one per cycle and stay at all-ones once they reach it.
- R9: Under output back-pressure, no byte is lost, duplicated or reordered, and a stalled output byte holds steady.
- R10: A candidate token longer than `HOLD_DEPTH` bytes is not held. Its bytes, including those beyond the store, appear on the output intact.
- R11: While a token is held, a packet with an invalid PID releases the token intact, is itself discarded, and counts as a PID error.
- R12: After reset, `out_valid` is 0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_in_nak_en | input | 1 | Enable IN+NAK discarding |
| cfg_ping_nak_en | input | 1 | Enable PING+NAK discarding |
| cfg_timeout_bits | input | TO_W | Bit times a held token waits for a following packet |
| bit_tick | input | 1 | One pulse per bus bit time |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can accept |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of an output packet |
| out_eop | output | 1 | Last byte of an output packet |
| drop_count | output | CNT_W | Saturating count of discarded polling pairs |
| pid_err_count | output | CNT_W | Saturating count of PID check failures |

## Verification
The bench builds the block with `CNT_W`=4, so `drop_count` saturates after fifteen discarded pairs, and saturation is reached in a short run. `HOLD_DEPTH` stays at 3, the length of a normal token, so a five-byte IN packet exercises the over-length release into pass-through. `TO_W`=8 keeps the timeout short: with a six-bit-time limit and one tick per clock, the release cycle can be observed directly. The other tests keep `bit_tick` low so that held tokens wait indefinitely.

// File: rtl/usb_nakf_pkg.sv
`timescale 1ns/1ps
package usb_nakf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_DROP,
    ST_COLLECT,
    ST_HELD,
    ST_FLUSH
  } nakf_state_e;

  typedef enum logic [1:0] {
    PK_OTHER,
    PK_IN,
    PK_PING,
    PK_NAK
  } pid_kind_e;

  localparam logic [3:0] PID_LO_IN   = 4'b1001;
  localparam logic [3:0] PID_LO_PING = 4'b0100;
  localparam logic [3:0] PID_LO_NAK  = 4'b1010;

endpackage

// File: rtl/usb_pid_chk.sv
`timescale 1ns/1ps
module usb_pid_chk
  import usb_nakf_pkg::*;
(
  input  logic [7:0] pid_byte,
  output logic       pid_ok,
  output pid_kind_e  kind
);

  always_comb begin
    pid_ok = (pid_byte[7:4] == ~pid_byte[3:0]);
    unique case (pid_byte[3:0])
      PID_LO_IN:   kind = PK_IN;
      PID_LO_PING: kind = PK_PING;
      PID_LO_NAK:  kind = PK_NAK;
      default:     kind = PK_OTHER;
    endcase
  end

endmodule

// File: rtl/usb_hold_buf.sv
`timescale 1ns/1ps
module usb_hold_buf #(
  parameter int DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_wr,
  input  logic       wr,
  input  logic [7:0] wr_data,
  input  logic       wr_eop,
  input  logic       rd_adv,
  output logic [7:0] rd_data,
  output logic       rd_eop,
  output logic       rd_first,
  output logic       rd_last,
  output logic       full
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] eop_v;
  logic [CW-1:0]    cnt_q;
  logic [IW-1:0]    rd_q;
  logic [IW-1:0]    wr_idx;

  assign wr_idx   = IW'(cnt_q);
  assign full     = (cnt_q == CW'(DEPTH));
  assign rd_data  = mem[rd_q];
  assign rd_eop   = eop_v[rd_q];
  assign rd_first = (rd_q == '0);
  assign rd_last  = ((CW'(rd_q) + CW'(1)) == cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rd_q  <= '0;
    end else begin
      if (clr_wr) begin
        cnt_q <= CW'(1);
        rd_q  <= '0;
      end else begin
        if (wr) cnt_q <= cnt_q + CW'(1);
        if (rd_adv) rd_q <= rd_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clr_wr) begin
      mem[0]   <= wr_data;
      eop_v[0] <= wr_eop;
    end else if (wr) begin
      mem[wr_idx]   <= wr_data;
      eop_v[wr_idx] <= wr_eop;
    end
  end

  AST_BUF_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr_wr) |-> !full); // R10

endmodule

// File: rtl/usb_sat_cnt.sv
`timescale 1ns/1ps
module usb_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   count <= '0;
    else if (inc && (count != '1)) count <= count + W'(1);
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((count == $past(count)) || (count == $past(count) + W'(1)))); // R8

  AST_CNT_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '1) |=> (count == '1)); // R8

endmodule

// File: rtl/usb_nak_filter.sv
`timescale 1ns/1ps
module usb_nak_filter
  import usb_nakf_pkg::*;
#(
  parameter int HOLD_DEPTH = 3,
  parameter int CNT_W      = 16,
  parameter int TO_W       = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_in_nak_en,
  input  logic             cfg_ping_nak_en,
  input  logic [TO_W-1:0]  cfg_timeout_bits,
  input  logic             bit_tick,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic [CNT_W-1:0] drop_count,
  output logic [CNT_W-1:0] pid_err_count
);

  nakf_state_e state_q, state_d;
  logic        cont_q, cont_d;

  logic        pid_ok;
  pid_kind_e   kind;
  logic        hold_kind, is_nak;

  logic        buf_clr, buf_wr, buf_adv;
  logic [7:0]  buf_data;
  logic        buf_eop, buf_first, buf_last, buf_full;

  logic [TO_W-1:0] to_cnt_q;
  logic            to_hit;
  logic            drop_inc, err_inc;

  usb_pid_chk u_pid (
    .pid_byte (in_data),
    .pid_ok   (pid_ok),
    .kind     (kind)
  );

  assign hold_kind = pid_ok &&
                     (((kind == PK_IN)   && cfg_in_nak_en) ||
                      ((kind == PK_PING) && cfg_ping_nak_en));
  assign is_nak    = pid_ok && (kind == PK_NAK);

  usb_hold_buf #(.DEPTH(HOLD_DEPTH)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_wr   (buf_clr),
    .wr       (buf_wr),
    .wr_data  (in_data),
    .wr_eop   (in_eop),
    .rd_adv   (buf_adv),
    .rd_data  (buf_data),
    .rd_eop   (buf_eop),
    .rd_first (buf_first),
    .rd_last  (buf_last),
    .full     (buf_full)
  );

  // Timeout: bit times spent waiting in the held state
  assign to_hit = (to_cnt_q >= cfg_timeout_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   to_cnt_q <= '0;
    else if (state_q != ST_HELD)  to_cnt_q <= '0;
    else if (bit_tick && !to_hit) to_cnt_q <= to_cnt_q + TO_W'(1);
  end

  always_comb begin
    state_d   = state_q;
    cont_d    = cont_q;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = in_data;
    out_sop   = in_sop;
    out_eop   = in_eop;
    buf_clr   = 1'b0;
    buf_wr    = 1'b0;
    buf_adv   = 1'b0;
    drop_inc  = 1'b0;
    err_inc   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          if (!in_sop) begin
            in_ready = 1'b1;              // stray byte outside a packet
          end else if (!pid_ok) begin
            in_ready = 1'b1;
            err_inc  = 1'b1;
            if (!in_eop) state_d = ST_DROP;
          end else if (hold_kind) begin
            in_ready = 1'b1;
            buf_clr  = 1'b1;
            state_d  = in_eop ? ST_HELD : ST_COLLECT;
          end else begin
            out_valid = 1'b1;
            in_ready  = out_ready;
            if (out_ready && !in_eop) state_d = ST_PASS;
          end
        end
      end
      ST_PASS: begin
        out_valid = in_valid;
        in_ready  = out_ready;
        if (in_valid && out_ready && in_eop) state_d = ST_IDLE;
      end
      ST_DROP: begin
        in_ready = 1'b1;
        if (in_valid && in_eop) state_d = ST_IDLE;
      end
      ST_COLLECT: begin
        if (in_valid) begin
          if (buf_full) begin
            state_d = ST_FLUSH;
            cont_d  = 1'b1;
          end else begin
            in_ready = 1'b1;
            buf_wr   = 1'b1;
            if (in_eop) state_d = ST_HELD;
          end
        end
      end
      ST_HELD: begin
        if (in_valid && in_sop) begin
          if (is_nak) begin
            in_ready = 1'b1;
            drop_inc = 1'b1;
            state_d  = in_eop ? ST_IDLE : ST_DROP;
          end else begin
            state_d = ST_FLUSH;
            cont_d  = 1'b0;
          end
        end else begin
          in_ready = in_valid;
          if (to_hit) begin
            state_d = ST_FLUSH;
            cont_d  = 1'b0;
          end
        end
      end
      ST_FLUSH: begin
        out_valid = 1'b1;
        out_data  = buf_data;
        out_sop   = buf_first;
        out_eop   = buf_eop;
        if (out_ready) begin
          buf_adv = 1'b1;
          if (buf_last) state_d = cont_q ? ST_PASS : ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cont_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cont_q  <= cont_d;
    end
  end

  usb_sat_cnt #(.W(CNT_W)) u_drop_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (drop_inc),
    .count (drop_count)
  );

  usb_sat_cnt #(.W(CNT_W)) u_err_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (err_inc),
    .count (pid_err_count)
  );

  AST_BADPID_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && in_valid && in_sop && !pid_ok) |-> !out_valid); // R1

  AST_NAK_PAIR_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HELD && in_valid && in_sop && is_nak)
      |=> (drop_count != $past(drop_count)) || (drop_count == '1)); // R3

  AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HELD && to_hit && !(in_valid && in_sop)) |=> (state_q == ST_FLUSH)); // R7

  AST_FLUSH_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FLUSH && out_valid && !out_ready)
      |=> out_valid && $stable(out_data) && $stable(out_sop)); // R9

endmodule

// File: tb/tb_usb_nak_filter.sv
`timescale 1ns/1ps
module tb_usb_nak_filter;

  localparam int CNT_W = 4;
  localparam int TO_W  = 8;
  localparam int HOLD_DEPTH = 3;

  typedef logic [7:0] pkt_t [8];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_in_nak_en = 1'b1;
  logic cfg_ping_nak_en = 1'b1;
  logic [TO_W-1:0] cfg_timeout_bits = 8'd200;
  logic bit_tick = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic in_sop = 1'b0;
  logic in_eop = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [7:0] out_data;
  logic out_sop, out_eop;
  logic [CNT_W-1:0] drop_count, pid_err_count;

  int checks = 0;
  int errors = 0;
  int exp_drop = 0;
  int exp_err = 0;
  bit finished = 1'b0;
  bit stall_mode = 1'b0;
  logic [7:0] lfsr = 8'hA7;

  logic [9:0] capq [$];
  logic [9:0] expq [$];

  always #10 clk = ~clk;   // 50 MHz

  usb_nak_filter #(.HOLD_DEPTH(HOLD_DEPTH), .CNT_W(CNT_W), .TO_W(TO_W)) dut (
    .clk, .rst_n, .cfg_in_nak_en, .cfg_ping_nak_en, .cfg_timeout_bits, .bit_tick,
    .in_valid, .in_ready, .in_data, .in_sop, .in_eop,
    .out_valid, .out_ready, .out_data, .out_sop, .out_eop,
    .drop_count, .pid_err_count
  );

  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = stall_mode ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    #5;
    if (rst_n && out_valid && out_ready) capq.push_back({out_sop, out_eop, out_data});
  end

  task automatic chk_val(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_stream(input string req);
    checks++;
    if (capq.size() != expq.size()) begin
      errors++;
      $display("FAIL %s: actual %0d bytes expected %0d bytes", req, capq.size(), expq.size());
    end else begin
      for (int i = 0; i < capq.size(); i++) begin
        if (capq[i] != expq[i]) begin
          errors++;
          $display("FAIL %s: byte %0d actual %h expected %h", req, i, capq[i], expq[i]);
          break;
        end
      end
    end
    capq.delete();
    expq.delete();
  endtask

  task automatic send_pkt(input pkt_t b, input int n);
    for (int i = 0; i < n; i++) begin
      bit taken;
      in_valid = 1'b1;
      in_data  = b[i];
      in_sop   = (i == 0);
      in_eop   = (i == n - 1);
      do begin
        #5;
        taken = in_ready;
        @(negedge clk);
      end while (!taken);
    end
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_eop   = 1'b0;
  endtask

  task automatic exp_pkt(input pkt_t b, input int n);
    for (int i = 0; i < n; i++)
      expq.push_back({(i == 0), (i == n - 1), b[i]});
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int sat_inc(input int v);
    return (v >= (1 << CNT_W) - 1) ? v : v + 1;
  endfunction

  localparam pkt_t P_IN    = '{8'h69, 8'h12, 8'h34, 0, 0, 0, 0, 0};
  localparam pkt_t P_PING  = '{8'hB4, 8'h21, 8'h43, 0, 0, 0, 0, 0};
  localparam pkt_t P_NAK   = '{8'h5A, 0, 0, 0, 0, 0, 0, 0};
  localparam pkt_t P_ACK   = '{8'hD2, 0, 0, 0, 0, 0, 0, 0};
  localparam pkt_t P_STALL = '{8'h1E, 0, 0, 0, 0, 0, 0, 0};
  localparam pkt_t P_SOF   = '{8'hA5, 8'h7F, 8'h08, 0, 0, 0, 0, 0};
  localparam pkt_t P_DATA1 = '{8'h4B, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 0, 0, 0};
  localparam pkt_t P_DATA0 = '{8'hC3, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 0};
  localparam pkt_t P_BAD   = '{8'h66, 8'h55, 8'h44, 0, 0, 0, 0, 0};
  localparam pkt_t P_INLNG = '{8'h69, 8'h10, 8'h20, 8'h30, 8'h40, 0, 0, 0};

  task automatic t_reset;
    chk_val("R12 out_valid", int'(out_valid), 0);
    chk_val("R12 drop_count", int'(drop_count), 0);
    chk_val("R12 pid_err_count", int'(pid_err_count), 0);
  endtask

  task automatic t_in_nak;   // R3
    send_pkt(P_IN, 3); send_pkt(P_NAK, 1); settle(10);
    exp_drop = sat_inc(exp_drop);
    chk_stream("R3 IN+NAK discarded");
    chk_val("R3 drop_count", int'(drop_count), exp_drop);
  endtask

  task automatic t_ping_nak; // R4
    send_pkt(P_PING, 3); send_pkt(P_NAK, 1); settle(10);
    exp_drop = sat_inc(exp_drop);
    chk_stream("R4 PING+NAK discarded");
    chk_val("R4 drop_count", int'(drop_count), exp_drop);
  endtask

  task automatic t_in_data;  // R5
    send_pkt(P_IN, 3); send_pkt(P_DATA1, 5); send_pkt(P_ACK, 1); settle(10);
    exp_pkt(P_IN, 3); exp_pkt(P_DATA1, 5); exp_pkt(P_ACK, 1);
    chk_stream("R5 IN+DATA1+ACK intact");
    send_pkt(P_PING, 3); send_pkt(P_STALL, 1); settle(10);
    exp_pkt(P_PING, 3); exp_pkt(P_STALL, 1);
    chk_stream("R5 PING+STALL intact");
    chk_val("R5 drop_count unchanged", int'(drop_count), exp_drop);
  endtask

  task automatic t_sof;      // R2
    send_pkt(P_SOF, 3); settle(6);
    exp_pkt(P_SOF, 3);
    chk_stream("R2 SOF not held");
    send_pkt(P_NAK, 1); send_pkt(P_DATA0, 7); settle(10);
    exp_pkt(P_NAK, 1); exp_pkt(P_DATA0, 7);
    chk_stream("R2 lone NAK and DATA0 pass");
  endtask

  task automatic t_disabled; // R6
    cfg_in_nak_en = 1'b0;
    send_pkt(P_IN, 3); send_pkt(P_NAK, 1);
    send_pkt(P_PING, 3); send_pkt(P_NAK, 1); settle(10);
    exp_pkt(P_IN, 3); exp_pkt(P_NAK, 1);
    exp_drop = sat_inc(exp_drop);
    chk_stream("R6 IN pair passes with IN filter off");
    chk_val("R6 drop_count", int'(drop_count), exp_drop);
    cfg_in_nak_en = 1'b1;
  endtask

  task automatic t_badpid;   // R1, R11
    send_pkt(P_BAD, 3); settle(6);
    exp_err = sat_inc(exp_err);
    chk_stream("R1 bad PID discarded");
    chk_val("R1 pid_err_count", int'(pid_err_count), exp_err);
    send_pkt(P_IN, 3); send_pkt(P_BAD, 3); settle(10);
    exp_err = sat_inc(exp_err);
    exp_pkt(P_IN, 3);
    chk_stream("R11 held IN released by bad packet");
    chk_val("R11 pid_err_count", int'(pid_err_count), exp_err);
  endtask

  task automatic t_timeout;  // R7
    cfg_timeout_bits = 8'd6;
    bit_tick = 1'b1;
    send_pkt(P_IN, 3); settle(2);
    chk_val("R7 still held", capq.size(), 0);
    settle(20);
    exp_pkt(P_IN, 3);
    chk_stream("R7 released after timeout");
    bit_tick = 1'b0;
    cfg_timeout_bits = 8'd200;
  endtask

  task automatic t_long_token; // R10
    send_pkt(P_INLNG, 5); settle(10);
    exp_pkt(P_INLNG, 5);
    chk_stream("R10 over-length token intact");
  endtask

  task automatic t_backpressure; // R9
    stall_mode = 1'b1;
    send_pkt(P_IN, 3); send_pkt(P_DATA0, 7); send_pkt(P_ACK, 1);
    send_pkt(P_SOF, 3); send_pkt(P_PING, 3); send_pkt(P_NAK, 1);
    send_pkt(P_DATA1, 5);
    settle(40);
    exp_pkt(P_IN, 3); exp_pkt(P_DATA0, 7); exp_pkt(P_ACK, 1);
    exp_pkt(P_SOF, 3); exp_pkt(P_DATA1, 5);
    exp_drop = sat_inc(exp_drop);
    chk_stream("R9 stream under back-pressure");
    chk_val("R9 drop_count", int'(drop_count), exp_drop);
    stall_mode = 1'b0;
  endtask

  task automatic t_saturate; // R8
    for (int k = 0; k < 16; k++) begin
      send_pkt(P_IN, 3); send_pkt(P_NAK, 1);
      exp_drop = sat_inc(exp_drop);
    end
    settle(10);
    chk_stream("R8 pairs discarded");
    chk_val("R8 drop_count saturated", int'(drop_count), (1 << CNT_W) - 1);
    chk_val("R8 expected model", exp_drop, (1 << CNT_W) - 1);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(2);
    t_reset();
    t_in_nak();
    t_ping_nak();
    t_in_data();
    t_sof();
    t_disabled();
    t_badpid();
    t_timeout();
    t_long_token();
    t_backpressure();
    t_saturate();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule